// File: doc/BRIEF.md
# Load/Store Address and Alignment Unit

This unit sits at the memory-access front end of a 64-bit load-store pipeline. Each request carries a base register index and that register's value, a signed 16-bit displacement, an access size, a signedness choice and a load/store indication. The unit adds the sign-extended displacement to the base value to form the effective address. It checks the address against the access size and raises a misalignment flag when the address is not a multiple of the size. For a store, it produces a byte-enable mask that covers the addressed lanes. For a load, it picks the addressed bytes out of the 64-bit memory word that comes with the request, then sign-extends or zero-extends them into a 64-bit register result.

Register index zero always supplies a base of zero, so absolute addressing falls out of the normal path. Register-indirect addressing is simply a request whose displacement is zero. A single register stage holds the result.

Requests and results move over a valid/ready pair. A beat is accepted when `in_valid` and `in_ready` are both high. The result appears on the output one clock later. While `out_valid` is high and `out_ready` is low, the output is held and `in_ready` is low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.

Top module: `lsu_addr_align`

## Requirements
- R1: `out_addr` equals the base value plus `in_disp` sign-extended to 64 bits, taken modulo 2^64.
- R2: When `in_base_idx` is 0, the base is taken as zero whatever `in_base_val` holds. A zero displacement yields the base value unchanged.
- R3: `in_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `out_misaligned` is set exactly when the address modulo the size in bytes is not zero, so byte accesses are never flagged.
- R4: A flagged access returns `out_load_data` = 0 and `out_byte_en` = 0, whether it is a load or a store and whatever its signedness.
- R5: Memory lanes are big-endian. The byte at address offset o (the low 3 address bits) occupies bits 63-8o down to 56-8o of `in_mem_word`, and a multi-byte field runs from lower to higher offsets, most significant byte first.
- R6: With `in_unsigned` = 0, a byte, half-word or word load copies the top bit of the field into all upper result bits. With `in_unsigned` = 1, the upper bits are zero. For an 8-byte load, `in_unsigned` has no effect.
- R7: For an aligned store, `out_byte_en` bit i covers data bits 8i+7:8i, so offset o maps to bit 7-o, and the mask has exactly the size's number of bits set. `out_load_data` is 0 for a store. `out_byte_en` is 0 for a load.
- R8: A beat accepted at a clock edge appears with `out_valid` high after that edge. With no new beat and `out_ready` high, `out_valid` drops after the next edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_misaligned` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request beat valid |
| in_ready | output | 1 | Unit can take a request |
| in_base_idx | input | 5 | Base register index (0 reads as zero) |
| in_base_val | input | 64 | Value read from the base register |
| in_disp | input | 16 | Signed displacement |
| in_size | input | 2 | Access size code |
| in_unsigned | input | 1 | Zero-extend the loaded field |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_mem_word | input | 64 | Memory word holding the addressed bytes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Effective address |
| out_misaligned | output | 1 | Access not a multiple of its size |
| out_load_data | output | 64 | Extended load result |
| out_byte_en | output | 8 | Store lane mask |
| out_is_store | output | 1 | Result belongs to a store |

## Verification
Misalignment detection and the load path's extension can both act on the same beat. A signed load whose field would have a set top bit, sent to an odd offset, should be expanded to all ones, but the misalignment flag must win and force the result to zero. The bench sends such signed, misaligned loads and stores next to aligned loads of the same bytes. It checks the flag, a zero result and an empty mask against a bench-side model. A second case arrives in the same cycle: a stall held by `out_ready` while a fresh request is waiting. The bench checks that the held result stays put and that the waiting request goes through only after release.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  localparam int NUM_SIZES = 4;

  // number of bytes touched by an access of a given size code
  function automatic int size_bytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction
endpackage

// File: rtl/lsu_agu.sv
module lsu_agu #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] disp_ext;

  // index zero is hard-wired to the constant zero
  assign base_eff = (base_idx == '0) ? '0 : base_val;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign ea       = base_eff + disp_ext;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN/8)-1:0] ofs,
  input  logic [1:0]                size,
  input  logic                      is_store,
  output logic                      misaligned,
  output logic [XLEN/8-1:0]         byte_en
);
  localparam int BYTES = XLEN / 8;
  localparam int OFS_W = $clog2(BYTES);

  logic [OFS_W:0]   nbytes;
  logic [OFS_W-1:0] low_mask;

  assign nbytes     = (OFS_W+1)'(1) << size;
  assign low_mask   = nbytes[OFS_W-1:0] - 1'b1;
  assign misaligned = |(ofs & low_mask);

  // lane i carries data bits 8i+7:8i, which is address offset BYTES-1-i
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam logic [OFS_W:0] LANE_OFS = (OFS_W+1)'(BYTES - 1 - i);
    logic in_range;
    assign in_range   = (LANE_OFS >= {1'b0, ofs}) && (LANE_OFS < ({1'b0, ofs} + nbytes));
    assign byte_en[i] = is_store && !misaligned && in_range;
  end
endmodule

// File: rtl/lsu_extract.sv
module lsu_extract #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]           mem_word,
  input  logic [$clog2(XLEN/8)-1:0] ofs,
  input  logic [1:0]                size,
  input  logic                      uns,
  output logic [XLEN-1:0]           data
);
  localparam int BYTES = XLEN / 8;

  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] ext [lsu_pkg::NUM_SIZES];

  // move the addressed field down to bit 0 (big-endian lanes)
  always_comb begin
    int sh;
    sh = (BYTES - int'(ofs) - lsu_pkg::size_bytes(size)) * 8;
    if (sh < 0) sh = 0;
    shifted = mem_word >> sh;
  end

  for (genvar k = 0; k < lsu_pkg::NUM_SIZES; k++) begin : g_size
    localparam int FW = 8 << k;
    if (FW < XLEN) begin : g_narrow
      logic fill;
      assign fill   = !uns && shifted[FW-1];
      assign ext[k] = {{(XLEN-FW){fill}}, shifted[FW-1:0]};
    end else begin : g_full
      assign ext[k] = shifted;
    end
  end

  assign data = ext[size];
endmodule

// File: rtl/lsu_addr_align.sv
module lsu_addr_align #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RIDX_W-1:0] in_base_idx,
  input  logic [XLEN-1:0]   in_base_val,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [1:0]        in_size,
  input  logic              in_unsigned,
  input  logic              in_is_store,
  input  logic [XLEN-1:0]   in_mem_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_addr,
  output logic              out_misaligned,
  output logic [XLEN-1:0]   out_load_data,
  output logic [XLEN/8-1:0] out_byte_en,
  output logic              out_is_store
);
  localparam int BYTES = XLEN / 8;
  localparam int OFS_W = $clog2(BYTES);

  logic [XLEN-1:0]  ea;
  logic [OFS_W-1:0] ofs;
  logic             mis;
  logic [BYTES-1:0] be;
  logic [XLEN-1:0]  ext_data;
  logic [XLEN-1:0]  ld_data;
  logic             accept;

  lsu_agu #(.XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W)) u_agu (
    .base_idx (in_base_idx),
    .base_val (in_base_val),
    .disp     (in_disp),
    .ea       (ea)
  );

  assign ofs = ea[OFS_W-1:0];

  lsu_align_chk #(.XLEN(XLEN)) u_align (
    .ofs        (ofs),
    .size       (in_size),
    .is_store   (in_is_store),
    .misaligned (mis),
    .byte_en    (be)
  );

  lsu_extract #(.XLEN(XLEN)) u_extract (
    .mem_word (in_mem_word),
    .ofs      (ofs),
    .size     (in_size),
    .uns      (in_unsigned),
    .data     (ext_data)
  );

  assign ld_data  = (!in_is_store && !mis) ? ext_data : '0;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_misaligned <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) out_misaligned <= mis;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_addr      <= ea;
      out_load_data <= ld_data;
      out_byte_en   <= be;
      out_is_store  <= in_is_store;
    end
  end
endmodule

// File: rtl/lsu_addr_align_sva.sv
module lsu_addr_align_sva #(
  parameter int XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_addr,
  input logic              out_misaligned,
  input logic [XLEN-1:0]   out_load_data,
  input logic [XLEN/8-1:0] out_byte_en,
  input logic              out_is_store
);
  localparam int OFS_W = $clog2(XLEN/8);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !out_valid && !out_misaligned); // R10

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_load_data)
      && $stable(out_byte_en) && $stable(out_misaligned) && $stable(out_is_store)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_misaligned |-> out_load_data == '0 && out_byte_en == '0); // R4

  AST_STORE_MASK_SIZE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_store && !out_misaligned |->
      ($countones(out_byte_en) == 1 || $countones(out_byte_en) == 2 ||
       $countones(out_byte_en) == 4 || $countones(out_byte_en) == 8)); // R7

  AST_LOAD_NO_MASK: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_store |-> out_byte_en == '0); // R7

  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_store |-> out_load_data == '0); // R7

  AST_FULL_MASK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_store && out_byte_en == '1 |-> out_addr[OFS_W-1:0] == '0); // R3
endmodule

bind lsu_addr_align lsu_addr_align_sva #(.XLEN(XLEN)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_addr       (out_addr),
  .out_misaligned (out_misaligned),
  .out_load_data  (out_load_data),
  .out_byte_en    (out_byte_en),
  .out_is_store   (out_is_store)
);

// File: tb/tb_lsu_addr_align.sv
`timescale 1ns/1ps
module tb_lsu_addr_align;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [4:0]  in_base_idx;
  logic [63:0] in_base_val;
  logic [15:0] in_disp;
  logic [1:0]  in_size;
  logic        in_unsigned;
  logic        in_is_store;
  logic [63:0] in_mem_word;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_addr;
  logic        out_misaligned;
  logic [63:0] out_load_data;
  logic [7:0]  out_byte_en;
  logic        out_is_store;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lsu_addr_align dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_base_idx(in_base_idx), .in_base_val(in_base_val), .in_disp(in_disp),
    .in_size(in_size), .in_unsigned(in_unsigned), .in_is_store(in_is_store),
    .in_mem_word(in_mem_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_misaligned(out_misaligned), .out_load_data(out_load_data),
    .out_byte_en(out_byte_en), .out_is_store(out_is_store)
  );

  localparam logic [63:0] MEM_A = 64'h80_11_F2_33_94_55_E6_77;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side model written from the requirements
  task automatic model(input logic [4:0] idx, input logic [63:0] bv, input logic [15:0] d,
                       input logic [1:0] sz, input logic u, input logic st, input logic [63:0] mem,
                       output logic [63:0] ea, output logic mis, output logic [63:0] ld,
                       output logic [7:0] be);
    int nb;
    int o;
    logic [63:0] v;
    nb  = 1 << sz;
    ea  = ((idx == 5'd0) ? 64'd0 : bv) + {{48{d[15]}}, d};
    o   = int'(ea[2:0]);
    mis = (o % nb) != 0;
    ld  = '0;
    be  = '0;
    if (!mis) begin
      if (st) begin
        for (int b = 0; b < nb; b++) be[7 - (o + b)] = 1'b1;
      end else begin
        v = '0;
        for (int b = 0; b < nb; b++) v = (v << 8) | {56'd0, mem[63 - 8*(o+b) -: 8]};
        if (!u && nb < 8 && v[8*nb-1]) v = v | ~((64'd1 << (8*nb)) - 64'd1);
        ld = v;
      end
    end
  endtask

  task automatic drive(input logic [4:0] idx, input logic [63:0] bv, input logic [15:0] d,
                       input logic [1:0] sz, input logic u, input logic st, input logic [63:0] mem);
    in_valid    = 1'b1;
    in_base_idx = idx;
    in_base_val = bv;
    in_disp     = d;
    in_size     = sz;
    in_unsigned = u;
    in_is_store = st;
    in_mem_word = mem;
  endtask

  // one beat through the stage, compared with the model on all outputs
  task automatic beat(input logic [4:0] idx, input logic [63:0] bv, input logic [15:0] d,
                      input logic [1:0] sz, input logic u, input logic st, input logic [63:0] mem,
                      input string tag);
    logic [63:0] e_ea;
    logic        e_mis;
    logic [63:0] e_ld;
    logic [7:0]  e_be;
    model(idx, bv, d, sz, u, st, mem, e_ea, e_mis, e_ld, e_be);
    @(negedge clk);
    drive(idx, bv, d, sz, u, st, mem);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
    chk(out_addr == e_ea, {tag, " addr"}, out_addr, e_ea);
    chk(out_misaligned == e_mis, {tag, " misaligned"}, 64'(out_misaligned), 64'(e_mis));
    chk(out_load_data == e_ld, {tag, " data"}, out_load_data, e_ld);
    chk(out_byte_en == e_be, {tag, " byte_en"}, 64'(out_byte_en), 64'(e_be));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(5'd0, '0, '0, 2'd0, 1'b0, 1'b0, '0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", 64'(out_valid), 64'd0);
    chk(out_misaligned == 1'b0, "R10 reset flag", 64'(out_misaligned), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_reset_mid();
    out_ready = 1'b0;
    drive(5'd3, 64'h1001, 16'd0, 2'd3, 1'b0, 1'b0, MEM_A);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_misaligned == 1'b1, "R3 flag before reset", 64'(out_misaligned), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 mid reset valid", 64'(out_valid), 64'd0);
    chk(out_misaligned == 1'b0, "R10 mid reset flag", 64'(out_misaligned), 64'd0);
    rst = 1'b0; out_ready = 1'b1;
  endtask

  task automatic t_addr();
    beat(5'd4, 64'h0000_0000_0000_1000, 16'h0030, 2'd3, 1'b0, 1'b0, MEM_A, "R1 positive disp");
    beat(5'd4, 64'h0000_0000_0000_1000, 16'hFFF0, 2'd3, 1'b0, 1'b0, MEM_A, "R1 negative disp");
    beat(5'd9, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0010, 2'd3, 1'b0, 1'b0, MEM_A, "R1 wrap");
    chk(out_addr == 64'h8, "R1 wrap literal", out_addr, 64'h8);
  endtask

  task automatic t_r0();
    beat(5'd0, 64'hDEAD_BEEF_0000_0001, 16'h8000, 2'd0, 1'b0, 1'b0, MEM_A, "R2 absolute");
    chk(out_addr == 64'hFFFF_FFFF_FFFF_8000, "R2 absolute literal", out_addr, 64'hFFFF_FFFF_FFFF_8000);
    beat(5'd7, 64'h0000_0000_0000_2468, 16'h0000, 2'd2, 1'b0, 1'b0, MEM_A, "R2 register indirect");
    chk(out_addr == 64'h2468, "R2 indirect literal", out_addr, 64'h2468);
  endtask

  task automatic t_align();
    for (int sz = 0; sz < 4; sz++) begin
      for (int o = 0; o < 8; o++) begin
        beat(5'd2, 64'h100 + 64'(o), 16'd0, 2'(sz), 1'b0, 1'b0, MEM_A, "R3 size offset sweep");
      end
    end
    beat(5'd2, 64'h103, 16'd0, 2'd0, 1'b0, 1'b0, MEM_A, "R3 byte odd");
    chk(out_misaligned == 1'b0, "R3 byte never flagged", 64'(out_misaligned), 64'd0);
  endtask

  task automatic t_misalign_vs_ext();
    // signed half at offset 5 (0x55E6 would be positive) and offset 1 (0x11F2)
    beat(5'd2, 64'h205, 16'd0, 2'd1, 1'b0, 1'b0, MEM_A, "R4 signed half misaligned");
    chk(out_load_data == 64'd0, "R4 half data zero", out_load_data, 64'd0);
    // signed word at offset 2 would be 0xF2339455 -> negative
    beat(5'd2, 64'h202, 16'd0, 2'd2, 1'b0, 1'b0, MEM_A, "R4 signed word misaligned");
    chk(out_misaligned == 1'b1 && out_load_data == 64'd0, "R4 flag wins over sign fill",
        out_load_data, 64'd0);
    beat(5'd2, 64'h203, 16'd0, 2'd3, 1'b0, 1'b1, MEM_A, "R4 store misaligned");
    chk(out_byte_en == 8'h00, "R4 store mask empty", 64'(out_byte_en), 64'd0);
  endtask

  task automatic t_lanes();
    for (int o = 0; o < 8; o++) begin
      beat(5'd1, 64'h300 + 64'(o), 16'd0, 2'd0, 1'b1, 1'b0, MEM_A, "R5 byte lane");
    end
    beat(5'd1, 64'h300, 16'd0, 2'd0, 1'b1, 1'b0, MEM_A, "R5 offset 0");
    chk(out_load_data == 64'h80, "R5 offset 0 is top byte", out_load_data, 64'h80);
    beat(5'd1, 64'h306, 16'd0, 2'd1, 1'b1, 1'b0, MEM_A, "R5 half order");
    chk(out_load_data == 64'hE677, "R5 half most significant first", out_load_data, 64'hE677);
  endtask

  task automatic t_ext();
    beat(5'd1, 64'h400, 16'd0, 2'd0, 1'b0, 1'b0, MEM_A, "R6 signed byte");
    chk(out_load_data == 64'hFFFF_FFFF_FFFF_FF80, "R6 signed byte literal",
        out_load_data, 64'hFFFF_FFFF_FFFF_FF80);
    beat(5'd1, 64'h404, 16'd0, 2'd2, 1'b0, 1'b0, MEM_A, "R6 signed word");
    chk(out_load_data == 64'hFFFF_FFFF_9455_E677, "R6 signed word literal",
        out_load_data, 64'hFFFF_FFFF_9455_E677);
    beat(5'd1, 64'h404, 16'd0, 2'd2, 1'b1, 1'b0, MEM_A, "R6 unsigned word");
    chk(out_load_data == 64'h0000_0000_9455_E677, "R6 unsigned word literal",
        out_load_data, 64'h9455_E677);
    beat(5'd1, 64'h401, 16'd0, 2'd0, 1'b0, 1'b0, MEM_A, "R6 signed positive byte");
    beat(5'd1, 64'h402, 16'd0, 2'd1, 1'b0, 1'b0, MEM_A, "R6 signed half");
    beat(5'd1, 64'h400, 16'd0, 2'd3, 1'b1, 1'b0, MEM_A, "R6 unsigned double");
    chk(out_load_data == MEM_A, "R6 double ignores unsigned", out_load_data, MEM_A);
  endtask

  task automatic t_store();
    for (int sz = 0; sz < 4; sz++) begin
      for (int o = 0; o < 8; o += (1 << sz)) begin
        beat(5'd6, 64'h500 + 64'(o), 16'd0, 2'(sz), 1'b0, 1'b1, MEM_A, "R7 store mask");
      end
    end
    beat(5'd6, 64'h504, 16'd0, 2'd1, 1'b0, 1'b1, MEM_A, "R7 half at 4");
    chk(out_byte_en == 8'b0000_1100, "R7 half at 4 literal", 64'(out_byte_en), 64'h0C);
    chk(out_is_store == 1'b1, "R7 store marker", 64'(out_is_store), 64'd1);
  endtask

  task automatic t_pipe();
    beat(5'd5, 64'h600, 16'd8, 2'd3, 1'b0, 1'b0, MEM_A, "R8 latency");
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 bubble drops valid", 64'(out_valid), 64'd0);
    // back-to-back beats
    @(negedge clk);
    drive(5'd5, 64'h700, 16'd0, 2'd0, 1'b1, 1'b0, MEM_A);
    @(negedge clk);
    chk(out_valid && out_addr == 64'h700, "R8 first of pair", out_addr, 64'h700);
    drive(5'd5, 64'h701, 16'd0, 2'd0, 1'b1, 1'b0, MEM_A);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_load_data == 64'h11, "R8 second of pair", out_load_data, 64'h11);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    drive(5'd8, 64'h800, 16'd0, 2'd0, 1'b0, 1'b0, MEM_A);
    @(negedge clk);
    // second request waits while the first is held
    drive(5'd8, 64'h804, 16'd0, 2'd2, 1'b1, 1'b0, MEM_A);
    chk(in_ready == 1'b0, "R9 ready low on stall", 64'(in_ready), 64'd0);
    repeat (2) begin
      @(negedge clk);
      chk(out_addr == 64'h800, "R9 addr held", out_addr, 64'h800);
      chk(out_load_data == 64'hFFFF_FFFF_FFFF_FF80, "R9 data held",
          out_load_data, 64'hFFFF_FFFF_FFFF_FF80);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_addr == 64'h804, "R9 waiting beat passes", out_addr, 64'h804);
    chk(out_load_data == 64'h9455_E677, "R9 waiting beat data", out_load_data, 64'h9455_E677);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_addr();
    t_r0();
    t_align();
    t_misalign_vs_ext();
    t_lanes();
    t_ext();
    t_store();
    t_pipe();
    t_stall();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule